// File: doc/BRIEF.md
# Prescaled Timer Time Base with Shadowed Reload

This block is the counting core of a general-purpose timer. A prescaler divides the timer clock by a programmable ratio, and each terminal count of the prescaler advances a counter. The counter can run upward, downward, or alternate direction (center-aligned). Each wrap of the counter may raise an overflow event. The event produces a one-cycle pulse and sets a sticky flag that software clears.

Software reaches the block through three write strobes: a control word, the period value and the prescaler divider. The period and the divider do not steer counting directly. Each one sits behind an active shadow copy. The period shadow follows a write at once, or waits for an overflow event when buffering is on. The divider shadow always waits for an overflow event. If the overflow event is disabled, the counter still wraps, but neither shadow is reloaded. The count is normally 16 bits wide, and a control bit widens both the count and the period to 32 bits.

Top module: `timer_base`

## Requirements
- R1: After reset, `count` is 0, `ovf_pulse`, `ovf_flag` and `run_active` are 0, and both shadows are 0.
- R2: A control write with `cfg_run`=1 on clock edge N sets `run_active` at edge N+1. The counter first advances at edge N+2 at the earliest. While `run_active` is 0, `count` does not change.
- R3: With an active divider value D, the counter advances exactly once every D+1 clock cycles while `run_active` is 1.
- R4: Mode `cfg_mode`=2'b00 (up) counts 0,1,...,P and then returns to 0, where P is the active period. The return to 0 is a wrap. With divider D, two wraps lie (P+1)(D+1) cycles apart.
- R5: Mode 2'b01 (down) counts P,...,0. The tick after 0 is a wrap. It loads the period that is active after that wrap, which is the written period when the event is enabled.
- R6: Modes 2'b10 and 2'b11 (center) count up to P and then down to 0, changing direction at both ends. Both turning points are wraps, so they lie P(D+1) cycles apart. The count seen in the cycle of the pulse is P-1 or 1.
- R7: With `cfg_buf`=0, a period write becomes the active period on the next clock edge.
- R8: With `cfg_buf`=1, a written period becomes active only at the next overflow event. The wrap interval in progress keeps the old period.
- R9: A divider write becomes active only at the next overflow event. The old ratio governs the interval in progress.
- R10: With `cfg_evt_en`=0, wraps still occur but give no pulse, do not set the flag, and reload neither shadow.
- R11: `ovf_flag` is set by an overflow event and stays set until a cycle with `flag_clr`=1. An event in the same cycle as `flag_clr` leaves the flag set.
- R12: With `cfg_wide`=0, only the low 16 bits of the written period are used. With `cfg_wide`=1, all 32 bits are used and `count` can exceed 16 bits.
- R13: `ovf_pulse` is high for exactly the cycle in which `count` shows the value written at the wrap. Each pulse follows a cycle with `run_active`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Write strobe for the control word |
| cfg_run | input | 1 | Counting enable request |
| cfg_buf | input | 1 | Period buffering enable |
| cfg_evt_en | input | 1 | Overflow event enable |
| cfg_mode | input | 2 | 00 up, 01 down, 1x center |
| cfg_wide | input | 1 | 32-bit count and period |
| per_we | input | 1 | Write strobe for the period |
| per_wdata | input | 2*CNT_W | Period value |
| psc_we | input | 1 | Write strobe for the divider |
| psc_wdata | input | PSC_W | Divider value D (ratio D+1) |
| flag_clr | input | 1 | Clears the overflow flag |
| count | output | 2*CNT_W | Current count |
| ovf_pulse | output | 1 | One-cycle overflow event |
| ovf_flag | output | 1 | Sticky overflow flag |
| run_active | output | 1 | Internal count enable |

## Verification
The bench builds the block with CNT_W=16 and PSC_W=8. The narrow divider makes every random divider value cheap to run. Because the counter wraps at 16 bits, a wide-mode down-count reload of 0x10003 shows that the upper half is live without any long count. The random mix uses small periods and dividers with random writes and clears, so reloads often land in the same cycle as events.

// File: rtl/timer_base.sv
module timer_base #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctrl_we,
  input  logic               cfg_run,
  input  logic               cfg_buf,
  input  logic               cfg_evt_en,
  input  logic [1:0]         cfg_mode,
  input  logic               cfg_wide,
  input  logic               per_we,
  input  logic [2*CNT_W-1:0] per_wdata,
  input  logic               psc_we,
  input  logic [PSC_W-1:0]   psc_wdata,
  input  logic               flag_clr,
  output logic [2*CNT_W-1:0] count,
  output logic               ovf_pulse,
  output logic               ovf_flag,
  output logic               run_active
);
  localparam int FW = 2 * CNT_W;

  logic             run_q, run_act, buf_q, evt_q, wide_q, dn_q;
  logic [1:0]       mode_q;
  logic [FW-1:0]    per_q, per_sh, cnt, cnt_nx, per_eff, per_new;
  logic [PSC_W-1:0] psc_q, psc_sh, psc_cnt;
  logic             dn_nx, wrap, tick, evt, pulse_q, flag_q;

  assign per_eff = wide_q ? per_sh : {{CNT_W{1'b0}}, per_sh[CNT_W-1:0]};
  assign per_new = wide_q ? per_q  : {{CNT_W{1'b0}}, per_q[CNT_W-1:0]};
  assign tick    = run_act && (psc_cnt == psc_sh);
  assign evt     = tick && wrap && evt_q;

  always_comb begin
    cnt_nx = cnt;
    dn_nx  = dn_q;
    wrap   = 1'b0;
    case (mode_q)
      2'b00: begin
        if (cnt >= per_eff) begin
          cnt_nx = '0;
          wrap   = 1'b1;
        end else cnt_nx = cnt + 1'b1;
      end
      2'b01: begin
        if (cnt == '0) begin
          cnt_nx = evt_q ? per_new : per_eff;
          wrap   = 1'b1;
        end else cnt_nx = cnt - 1'b1;
      end
      default: begin
        if (!dn_q) begin
          if (cnt >= per_eff) begin
            wrap   = 1'b1;
            dn_nx  = 1'b1;
            cnt_nx = (cnt == '0) ? '0 : cnt - 1'b1;
          end else cnt_nx = cnt + 1'b1;
        end else begin
          if (cnt == '0) begin
            wrap   = 1'b1;
            dn_nx  = 1'b0;
            cnt_nx = (per_eff == '0) ? '0 : {{(FW-1){1'b0}}, 1'b1};
          end else cnt_nx = cnt - 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      run_act <= 1'b0;
      buf_q   <= 1'b0;
      evt_q   <= 1'b0;
      wide_q  <= 1'b0;
      mode_q  <= 2'b00;
      dn_q    <= 1'b0;
      per_q   <= '0;
      per_sh  <= '0;
      psc_q   <= '0;
      psc_sh  <= '0;
      psc_cnt <= '0;
      cnt     <= '0;
      pulse_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      run_act <= run_q;
      if (ctrl_we) begin
        run_q  <= cfg_run;
        buf_q  <= cfg_buf;
        evt_q  <= cfg_evt_en;
        mode_q <= cfg_mode;
        wide_q <= cfg_wide;
      end
      if (per_we) per_q <= per_wdata;
      if (per_we && !buf_q) per_sh <= per_wdata;
      else if (evt)         per_sh <= per_q;
      if (psc_we) psc_q  <= psc_wdata;
      if (evt)    psc_sh <= psc_q;
      if (run_act) psc_cnt <= tick ? '0 : psc_cnt + 1'b1;
      if (tick) begin
        cnt  <= cnt_nx;
        dn_q <= dn_nx;
      end
      pulse_q <= evt;
      if (evt)           flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end

  assign count      = cnt;
  assign ovf_pulse  = pulse_q;
  assign ovf_flag   = flag_q;
  assign run_active = run_act;
endmodule

// File: rtl/timer_base_chk.sv
module timer_base_chk #(
  parameter int FW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctrl_we,
  input logic          cfg_run,
  input logic          flag_clr,
  input logic [FW-1:0] count,
  input logic          ovf_pulse,
  input logic          ovf_flag,
  input logic          run_active,
  input logic [1:0]    mode_q,
  input logic          evt_q
);
  AST_RUN_LAG: assert property (@(posedge clk) disable iff (!rst_n) (ctrl_we && cfg_run) |=> ##1 run_active); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !run_active |=> $stable(count)); // R2
  AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (ovf_pulse && mode_q == 2'b00 && $past(mode_q) == 2'b00) |-> count == '0); // R4
  AST_EVT_GATE: assert property (@(posedge clk) disable iff (!rst_n) ovf_pulse |-> $past(evt_q)); // R10
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n) ovf_pulse |-> ovf_flag); // R11
  AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n) (ovf_flag && !flag_clr) |=> ovf_flag); // R11
  AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n) flag_clr |=> (ovf_flag == ovf_pulse)); // R11
  AST_PULSE_RUN: assert property (@(posedge clk) disable iff (!rst_n) ovf_pulse |-> $past(run_active)); // R13
endmodule

bind timer_base timer_base_chk #(.FW(2*CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .cfg_run(cfg_run),
  .flag_clr(flag_clr), .count(count), .ovf_pulse(ovf_pulse),
  .ovf_flag(ovf_flag), .run_active(run_active), .mode_q(mode_q), .evt_q(evt_q)
);

// File: tb/timer_base_tb.sv
module timer_base_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;
  localparam int PW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctrl_we = 0, cfg_run = 0, cfg_buf = 0, cfg_evt_en = 0, cfg_wide = 0;
  logic [1:0] cfg_mode = 0;
  logic per_we = 0, psc_we = 0, flag_clr = 0;
  logic [2*CW-1:0] per_wdata = 0;
  logic [PW-1:0] psc_wdata = 0;
  logic [2*CW-1:0] count;
  logic ovf_pulse, ovf_flag, run_active;

  always #(CLK_PERIOD/2) clk = ~clk;

  timer_base #(.CNT_W(CW), .PSC_W(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .cfg_run(cfg_run), .cfg_buf(cfg_buf),
    .cfg_evt_en(cfg_evt_en), .cfg_mode(cfg_mode), .cfg_wide(cfg_wide),
    .per_we(per_we), .per_wdata(per_wdata), .psc_we(psc_we), .psc_wdata(psc_wdata),
    .flag_clr(flag_clr), .count(count), .ovf_pulse(ovf_pulse), .ovf_flag(ovf_flag),
    .run_active(run_active)
  );

  int n_chk = 0, n_err = 0, cyc_n = 0;
  string cur_req = "R1";

  // reference model
  logic [31:0] m_cnt, m_per, m_psh, t_pe, t_pn, t_nc;
  logic [PW-1:0] m_psc, m_pss, m_pc;
  logic [1:0] m_mode;
  bit m_run, m_act, m_buf, m_evt, m_wide, m_dn, m_pulse, m_flag;
  bit t_w, t_nd, t_tk, t_ev;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_per = 0; m_psh = 0; m_psc = 0; m_pss = 0; m_pc = 0; m_mode = 0;
      m_run = 0; m_act = 0; m_buf = 0; m_evt = 0; m_wide = 0; m_dn = 0; m_pulse = 0; m_flag = 0;
    end else begin
      t_pe = m_wide ? m_psh : (m_psh & 32'h0000_FFFF);
      t_pn = m_wide ? m_per : (m_per & 32'h0000_FFFF);
      t_tk = m_act && (m_pc == m_pss);
      t_nc = m_cnt; t_nd = m_dn; t_w = 0;
      if (m_mode == 2'b00) begin
        t_w = (m_cnt >= t_pe); t_nc = t_w ? 0 : m_cnt + 1;
      end else if (m_mode == 2'b01) begin
        t_w = (m_cnt == 0); t_nc = t_w ? (m_evt ? t_pn : t_pe) : m_cnt - 1;
      end else if (!m_dn) begin
        t_w = (m_cnt >= t_pe);
        if (t_w) begin t_nd = 1; t_nc = (m_cnt == 0) ? 0 : m_cnt - 1; end
        else t_nc = m_cnt + 1;
      end else begin
        t_w = (m_cnt == 0);
        if (t_w) begin t_nd = 0; t_nc = (t_pe == 0) ? 0 : 1; end
        else t_nc = m_cnt - 1;
      end
      t_ev = t_tk && t_w && m_evt;
      m_pulse = t_ev;
      if (t_ev) m_flag = 1; else if (flag_clr) m_flag = 0;
      if (t_tk) begin m_cnt = t_nc; m_dn = t_nd; end
      if (m_act) m_pc = t_tk ? 0 : m_pc + 1;
      if (t_ev) m_pss = m_psc;
      if (psc_we) m_psc = psc_wdata;
      if (per_we && !m_buf) m_psh = per_wdata; else if (t_ev) m_psh = m_per;
      if (per_we) m_per = per_wdata;
      m_act = m_run;
      if (ctrl_we) begin
        m_run = cfg_run; m_buf = cfg_buf; m_evt = cfg_evt_en; m_mode = cfg_mode; m_wide = cfg_wide;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    cyc_n++;
    if (rst_n) begin
      chk(count == m_cnt, cur_req, "count vs model", count, m_cnt);
      chk(ovf_pulse == m_pulse, "R13", "pulse vs model", ovf_pulse, m_pulse);
      chk(ovf_flag == m_flag, "R11", "flag vs model", ovf_flag, m_flag);
      chk(run_active == m_act, "R2", "run_active vs model", run_active, m_act);
    end
  endtask

  task automatic next_pulse(output int at);
    int k = 0;
    do begin cyc(); k++; end while (!ovf_pulse && k < 400);
    if (k >= 400) chk(1'b0, cur_req, "pulse timeout", 0, 1);
    at = cyc_n;
  endtask

  task automatic wr_ctrl(input bit r, input bit b, input bit e, input logic [1:0] m, input bit w);
    cfg_run = r; cfg_buf = b; cfg_evt_en = e; cfg_mode = m; cfg_wide = w; ctrl_we = 1;
    cyc(); ctrl_we = 0;
  endtask

  task automatic wr_per(input logic [31:0] v);
    per_wdata = v; per_we = 1; cyc(); per_we = 0;
  endtask

  task automatic wr_psc(input logic [PW-1:0] v);
    psc_wdata = v; psc_we = 1; cyc(); psc_we = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int p0, p1, p2;
    logic [31:0] mx;
    bit sawp;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(count == 0, "R1", "reset count", count, 0);
    chk(ovf_pulse == 0, "R1", "reset pulse", ovf_pulse, 0);
    chk(ovf_flag == 0, "R1", "reset flag", ovf_flag, 0);
    chk(run_active == 0, "R1", "reset run_active", run_active, 0);

    cur_req = "R4";
    wr_per(3);
    wr_ctrl(1, 0, 1, 2'b00, 0);
    chk(run_active == 0, "R2", "enable lag edge1", run_active, 0);
    cyc();
    chk(run_active == 1, "R2", "enable lag edge2", run_active, 1);
    chk(count == 0, "R2", "no advance yet", count, 0);
    cyc(); chk(count == 1, "R4", "up step 1", count, 1);
    cyc(); chk(count == 2, "R4", "up step 2", count, 2);
    cyc(); chk(count == 3, "R4", "up step 3", count, 3);
    cyc();
    chk(count == 0, "R4", "up wrap", count, 0);
    chk(ovf_pulse == 1, "R13", "pulse at wrap", ovf_pulse, 1);
    chk(ovf_flag == 1, "R11", "flag set", ovf_flag, 1);
    p0 = cyc_n; next_pulse(p1);
    chk(p1 - p0 == 4, "R4", "up gap P=3 D=0", p1 - p0, 4);

    cur_req = "R9";
    wr_psc(2);
    next_pulse(p2); chk(p2 - p1 == 4, "R9", "old divider kept", p2 - p1, 4);
    next_pulse(p0); chk(p0 - p2 == 12, "R3", "divider 3 gap", p0 - p2, 12);
    wr_psc(0); next_pulse(p0);

    cur_req = "R7";
    next_pulse(p0); wr_per(6);
    next_pulse(p1); chk(p1 - p0 == 7, "R7", "immediate period", p1 - p0, 7);

    cur_req = "R8";
    wr_ctrl(1, 1, 1, 2'b00, 0);
    next_pulse(p0); wr_per(2);
    next_pulse(p1); chk(p1 - p0 == 7, "R8", "buffered old period", p1 - p0, 7);
    next_pulse(p2); chk(p2 - p1 == 3, "R8", "buffered new period", p2 - p1, 3);

    cur_req = "R5";
    wr_ctrl(1, 0, 1, 2'b01, 0);
    wr_per(4);
    next_pulse(p0);
    chk(count == 4, "R5", "down reload", count, 4);
    next_pulse(p1); chk(p1 - p0 == 5, "R5", "down gap", p1 - p0, 5);

    cur_req = "R6";
    wr_ctrl(1, 0, 1, 2'b10, 0);
    next_pulse(p0); next_pulse(p0);
    chk(count == 3 || count == 1, "R6", "center turn value", count, 3);
    next_pulse(p1); chk(p1 - p0 == 4, "R6", "center gap", p1 - p0, 4);
    chk(count == 3 || count == 1, "R6", "center turn value", count, 1);
    next_pulse(p2); chk(p2 - p1 == 4, "R6", "center gap", p2 - p1, 4);

    cur_req = "R10";
    wr_ctrl(1, 1, 0, 2'b00, 0);
    wr_per(6); wr_psc(1);
    mx = 0; sawp = 0;
    for (int i = 0; i < 40; i++) begin
      cyc();
      if (count > mx) mx = count;
      if (ovf_pulse) sawp = 1;
    end
    chk(sawp == 0, "R10", "no pulse when disabled", sawp, 0);
    chk(mx == 4, "R10", "period not reloaded", mx, 4);
    wr_ctrl(1, 1, 1, 2'b00, 0);
    next_pulse(p0); next_pulse(p1);
    chk(p1 - p0 == 14, "R10", "reload deferred to enabled event", p1 - p0, 14);

    cur_req = "R11";
    wr_psc(0); wr_ctrl(1, 0, 1, 2'b00, 0); wr_per(0);
    next_pulse(p0); next_pulse(p0);
    flag_clr = 1;
    for (int i = 0; i < 4; i++) begin
      cyc(); chk(ovf_flag == 1, "R11", "set beats clear", ovf_flag, 1);
    end
    wr_ctrl(1, 0, 0, 2'b00, 0);
    cyc(); chk(ovf_flag == 0, "R11", "clear works", ovf_flag, 0);
    flag_clr = 0;
    cyc(); chk(ovf_flag == 0, "R11", "stays clear", ovf_flag, 0);
    wr_ctrl(1, 0, 1, 2'b00, 0);
    next_pulse(p0);
    wr_ctrl(1, 0, 0, 2'b00, 0);
    repeat (5) cyc();
    chk(ovf_flag == 1, "R11", "flag sticky", ovf_flag, 1);
    chk(ovf_pulse == 0, "R10", "no pulse while disabled", ovf_pulse, 0);
    flag_clr = 1; cyc(); flag_clr = 0; cyc();
    chk(ovf_flag == 0, "R11", "flag cleared", ovf_flag, 0);

    cur_req = "R12";
    wr_ctrl(1, 0, 1, 2'b01, 0);
    wr_per(32'h0001_0003);
    next_pulse(p0);
    chk(count == 3, "R12", "narrow reload", count, 3);
    wr_ctrl(1, 0, 1, 2'b01, 1);
    next_pulse(p0);
    chk(count == 32'h0001_0003, "R12", "wide reload", count, 32'h0001_0003);
    cyc();
    chk(count == 32'h0001_0002, "R12", "wide count down", count, 32'h0001_0002);

    rst_n = 0; repeat (2) @(negedge clk); rst_n = 1;
    for (int blk = 0; blk < 40; blk++) begin
      logic [1:0] md;
      md = 2'($urandom % 3);
      cur_req = (md == 0) ? "R4" : (md == 1) ? "R5" : "R6";
      wr_psc(PW'($urandom % 3));
      wr_per($urandom % 7);
      wr_ctrl(1, 1'($urandom % 2), ($urandom % 4) != 0, md, 0);
      for (int i = 0; i < 150; i++) begin
        per_we = ($urandom % 20) == 0; per_wdata = $urandom % 7;
        psc_we = ($urandom % 30) == 0; psc_wdata = PW'($urandom % 3);
        flag_clr = ($urandom % 16) == 0;
        cyc();
      end
      per_we = 0; psc_we = 0; flag_clr = 0;
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule